// File: doc/BRIEF.md
# Power-of-Two Converter Clock Prescaler

This block derives a slow clock for a data converter from one of two source clocks. A select input chooses the source. The block counts that source's ticks and divides them by a power of two. The ratio comes from an 8-bit one-hot code held in a memory-mapped register. An all-zero code means no division. A single set bit at position n means division by 2^(n+1), which covers ratios from 2 to 256.

The two source clocks are modelled as clock-enable strobes (`osc_tick`, `bus_tick`) in the single system clock domain. The block produces two outputs:
- a one-cycle strobe, `div_pulse`, once per divided period;
- a toggled clock-like output, `div_clk`, with a 50% duty cycle.

A code with more than one bit set is rejected. It sets a sticky error flag, which software reads and clears through a second word. New ratios wait for the end of the period in progress, so the outputs never show a shortened period. A change of source restarts the count from zero.

Top module: `conv_clk_prescaler`

## Requirements
- R1: After synchronous reset the divisor word reads 0, `err_flag` is 0, and the ratio is 1: `div_pulse` is high in the cycle after every selected source tick.
- R2: The divisor word is at byte offset 0x48. Bits 7:0 hold the code. On a read, `bus_rdata` shows the stored code zero-extended to 32 bits in the cycle after the read request. Write data in bits 31:8 is ignored. `bus_rdata` is 0 when no read is requested.
- R3: With only code bit n set, `div_pulse` repeats every 2^(n+1) selected ticks. It is one cycle wide and rises in the cycle after the tick that ends the period.
- R4: For ratios N of 2 or more, `div_clk` is low for the first N/2 ticks of each period and high for the last N/2. At ratio 1, `div_clk` is a registered copy of the selected tick.
- R5: A write of a code with two or more bits set is not stored. The ratio in effect does not change, and `err_flag` goes to 1 in the cycle after the write.
- R6: The error word is at byte offset 0x4C, with the flag in bit 0. The flag stays set until a write to that word with bit 0 equal to 1. A write with bit 0 equal to 0 leaves it set. The `err_flag` output mirrors the flag.
- R7: A newly written ratio takes effect only when the period in progress ends. That period keeps its old length.
- R8: When `src_sel` is 0, `osc_tick` is counted. When it is 1, `bus_tick` is counted. The unselected tick has no effect.
- R9: A change of `src_sel` restarts the period: the counter returns to zero, `div_clk` goes low, the stored ratio is loaded, and any tick in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Source choice: 0 oscillator tick, 1 bus tick |
| osc_tick | input | 1 | Oscillator-derived clock enable |
| bus_tick | input | 1 | Bus-clock-derived clock enable |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| div_pulse | output | 1 | One-cycle strobe per divided period |
| div_clk | output | 1 | Divided clock, 50% duty for ratios of 2 or more |
| err_flag | output | 1 | Sticky invalid-code flag |

## Verification
The hardest case is a ratio change in the middle of a long period. The bench sets the 256 ratio and locks onto a strobe. It writes the divide-by-2 code ten cycles later and counts cycles up to the next strobe, which must still be 256 away, with a 2-cycle period after it. The source-change restart is reached by letting the oscillator advance the counter part way, switching to a bus tick held low, and then issuing single bus ticks one by one. The strobe must not appear before the eighth tick, even though the oscillator tick stays high throughout.

// File: rtl/cpre_pkg.sv
package cpre_pkg;
  localparam int BUS_W = 32;

  typedef enum logic {
    SRC_OSC = 1'b0,
    SRC_BUS = 1'b1
  } src_sel_e;
endpackage

// File: rtl/cpre_decode.sv
// One-hot divisor code decoder: flags codes with more than one bit set and
// converts a single set bit at position n into the shift amount n+1.
module cpre_decode #(
  parameter int CODE_W = 8,
  parameter int SH_W   = $clog2(CODE_W + 1)
) (
  input  logic [CODE_W-1:0] code,
  output logic              valid,
  output logic [SH_W-1:0]   sh
);
  logic [CODE_W-1:0] lower_set;
  logic [CODE_W-1:0] clash;

  genvar i;
  generate
    for (i = 0; i < CODE_W; i++) begin : g_scan
      if (i == 0) begin : g_first
        assign lower_set[i] = 1'b0;
      end else begin : g_rest
        assign lower_set[i] = lower_set[i-1] | code[i-1];
      end
    end
  endgenerate

  assign clash = code & lower_set;
  assign valid = ~|clash;

  always_comb begin
    sh = '0;
    for (int b = 0; b < CODE_W; b++) begin
      if (code[b]) sh = sh | SH_W'(b + 1);
    end
  end
endmodule

// File: rtl/cpre_regs.sv
// Register words: divisor code and sticky error flag.
module cpre_regs #(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 32,
  parameter int              CODE_W   = 8,
  parameter logic [ADDR_W-1:0] CODE_OFS = 8'h48,
  parameter logic [ADDR_W-1:0] ERR_OFS  = 8'h4C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              wr_code_ok,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CODE_W-1:0] code_q,
  output logic              err_q
);
  logic code_hit, err_hit;

  assign code_hit = bus_sel && (bus_addr == CODE_OFS);
  assign err_hit  = bus_sel && (bus_addr == ERR_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= '0;
      err_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (code_hit && bus_we) begin
        if (wr_code_ok) code_q <= bus_wdata[CODE_W-1:0];
        else            err_q  <= 1'b1;
      end
      if (err_hit && bus_we && bus_wdata[0]) err_q <= 1'b0;
      bus_rdata <= '0;
      if (bus_sel && !bus_we) begin
        if (code_hit)     bus_rdata <= DATA_W'(code_q);
        else if (err_hit) bus_rdata <= DATA_W'(err_q);
      end
    end
  end

  // R5
  bad_code_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (code_hit && bus_we && !wr_code_ok) |=> (err_q && $stable(code_q)));

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (err_hit && bus_we && bus_wdata[0]) |=> !err_q);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:CODE_W] == '0);
endmodule

// File: rtl/cpre_divider.sv
// Tick counter with boundary-aligned ratio loading and divided outputs.
module cpre_divider #(
  parameter int CNT_W = 8,
  parameter int SH_W  = $clog2(CNT_W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            restart,
  input  logic [SH_W-1:0] pend_sh,
  output logic            pulse,
  output logic            div_clk
);
  logic [SH_W-1:0]  act_sh;
  logic [CNT_W-1:0] cnt, cnt_nxt, last;
  logic [CNT_W:0]   lim, half;
  logic             wrap;

  assign lim     = {{CNT_W{1'b0}}, 1'b1} << act_sh;
  assign half    = lim >> 1;
  assign last    = lim[CNT_W-1:0] - CNT_W'(1);
  assign wrap    = tick && (cnt == last);
  assign cnt_nxt = wrap ? '0 : cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_sh  <= '0;
      pulse   <= 1'b0;
      div_clk <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      act_sh  <= pend_sh;
      pulse   <= 1'b0;
      div_clk <= 1'b0;
    end else begin
      pulse <= wrap;
      if (tick) begin
        cnt <= cnt_nxt;
        if (wrap)             div_clk <= (pend_sh == '0);
        else if (act_sh == '0) div_clk <= 1'b1;
        else                  div_clk <= ({1'b0, cnt_nxt} >= half);
      end else if (act_sh == '0) begin
        div_clk <= 1'b0;
      end
      if (wrap) act_sh <= pend_sh;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);

  // R3
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(tick));

  // R7
  ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (act_sh != $past(act_sh)) |-> $past(wrap || restart));

  // R4
  dclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(restart) && ($past(act_sh) != '0)) |-> $stable(div_clk));
endmodule

// File: rtl/conv_clk_prescaler.sv
module conv_clk_prescaler #(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = cpre_pkg::BUS_W,
  parameter int              CODE_W   = 8,
  parameter logic [ADDR_W-1:0] CODE_OFS = 8'h48,
  parameter logic [ADDR_W-1:0] ERR_OFS  = 8'h4C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_sel,
  input  logic              osc_tick,
  input  logic              bus_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              div_pulse,
  output logic              div_clk,
  output logic              err_flag
);
  import cpre_pkg::*;

  localparam int SH_W  = $clog2(CODE_W + 1);
  localparam int CNT_W = CODE_W;

  logic              src_q, restart, tick;
  logic              wr_ok, stored_ok;
  logic [SH_W-1:0]   wr_sh, stored_sh;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= src_sel;
    else     src_q <= src_sel;
  end

  assign restart = (src_sel != src_q);
  assign tick    = (src_sel_e'(src_sel) == SRC_BUS) ? bus_tick : osc_tick;

  cpre_decode #(.CODE_W(CODE_W), .SH_W(SH_W)) u_wr_dec (
    .code  (bus_wdata[CODE_W-1:0]),
    .valid (wr_ok),
    .sh    (wr_sh)
  );

  cpre_decode #(.CODE_W(CODE_W), .SH_W(SH_W)) u_st_dec (
    .code  (code_q),
    .valid (stored_ok),
    .sh    (stored_sh)
  );

  cpre_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
    .CODE_OFS(CODE_OFS), .ERR_OFS(ERR_OFS)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .wr_code_ok (wr_ok),
    .bus_rdata  (bus_rdata),
    .code_q     (code_q),
    .err_q      (err_flag)
  );

  cpre_divider #(.CNT_W(CNT_W), .SH_W(SH_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .restart (restart),
    .pend_sh (stored_sh),
    .pulse   (div_pulse),
    .div_clk (div_clk)
  );

  // R5
  stored_code_valid_chk: assert property (@(posedge clk) disable iff (rst)
    stored_ok);

  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!div_pulse && !div_clk));

  logic unused_wr_sh;
  assign unused_wr_sh = ^wr_sh;
endmodule

// File: tb/conv_clk_prescaler_tb.sv
module conv_clk_prescaler_tb;
  localparam logic [7:0] CODE_OFS = 8'h48;
  localparam logic [7:0] ERR_OFS  = 8'h4C;

  localparam int NV = 9;
  localparam logic [7:0] V_CODE [NV] = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08,
                                         8'h10, 8'h20, 8'h40, 8'h80};
  localparam int V_N  [NV] = '{1, 2, 4, 8, 16, 32, 64, 128, 256};
  localparam int V_HI [NV] = '{1, 1, 2, 4, 8, 16, 32, 64, 128};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_sel = 1'b0, osc_tick = 1'b1, bus_tick = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        div_pulse, div_clk, err_flag;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  conv_clk_prescaler u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .osc_tick(osc_tick),
    .bus_tick(bus_tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div_pulse(div_pulse), .div_clk(div_clk), .err_flag(err_flag)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_pulse(output int cyc, output int highs);
    cyc = 0; highs = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      cyc++;
      if (div_clk) highs++;
      if (div_pulse) return;
    end
    check("R3", "strobe timeout", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int c, h, total, early;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1", "err_flag after reset", err_flag, 0);
    bus_read(CODE_OFS, rd);
    check("R1", "code after reset", rd, 0);
    wait_pulse(c, h);
    wait_pulse(c, h);
    check("R1", "period after reset", c, 1);

    // R3 R4 R2 vector walk
    for (int i = 0; i < NV; i++) begin
      bus_write(CODE_OFS, {24'h0, V_CODE[i]});
      bus_read(CODE_OFS, rd);
      check("R2", "readback", rd, V_CODE[i]);
      wait_pulse(c, h);
      wait_pulse(c, h);
      check("R3", "period", c, V_N[i]);
      check("R4", "high samples", h, V_HI[i]);
    end

    // R2 reserved bits ignored
    bus_write(CODE_OFS, 32'hFFFF_FF04);
    bus_read(CODE_OFS, rd);
    check("R2", "reserved write readback", rd, 32'h4);
    wait_pulse(c, h);
    wait_pulse(c, h);
    check("R2", "period after reserved write", c, 8);
    bus_read(8'h10, rd);
    check("R2", "unmapped read", rd, 0);

    // R5 invalid code
    bus_write(CODE_OFS, 32'h0000_0003);
    check("R5", "err_flag after bad code", err_flag, 1);
    bus_read(CODE_OFS, rd);
    check("R5", "code kept", rd, 32'h4);
    wait_pulse(c, h);
    wait_pulse(c, h);
    check("R5", "ratio kept", c, 8);

    // R6 error word
    bus_read(ERR_OFS, rd);
    check("R6", "error word read", rd, 1);
    bus_write(ERR_OFS, 32'h0);
    check("R6", "flag held on zero write", err_flag, 1);
    bus_write(ERR_OFS, 32'h1);
    check("R6", "flag cleared", err_flag, 0);

    // R7 mid-period change keeps the running period
    bus_write(CODE_OFS, 32'h80);
    wait_pulse(c, h);
    wait_pulse(c, h);
    total = 0; early = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      total++;
      if (div_pulse) early++;
    end
    bus_write(CODE_OFS, 32'h01);
    total += 2;
    if (div_pulse) early++;
    wait_pulse(c, h);
    total += c;
    check("R7", "early strobe count", early, 0);
    check("R7", "old period finished", total, 256);
    wait_pulse(c, h);
    check("R7", "new period", c, 2);

    // R8 R9 source change restart
    bus_write(CODE_OFS, 32'h04);
    wait_pulse(c, h);
    wait_pulse(c, h);
    repeat (3) @(negedge clk);
    bus_tick = 1'b0;
    src_sel = 1'b1;
    @(negedge clk);
    check("R9", "div_clk low after restart", div_clk, 0);
    early = 0;
    for (int k = 1; k <= 8; k++) begin
      bus_tick = 1'b1;
      @(negedge clk);
      bus_tick = 1'b0;
      if (k < 8 && div_pulse) early++;
      if (k == 8) check("R9", "strobe on eighth bus tick", div_pulse, 1);
      @(negedge clk);
      if (div_pulse) early++;
    end
    check("R8", "strobes from unselected tick", early, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule